// File: doc/BRIEF.md
# Transmit/Receive DMA Bus Arbiter

This block decides which of two DMA channels, one moving transmit data and one moving receive data, owns a shared bus master port. Each channel raises a request and holds it while it has bursts to move; the arbiter answers with a one-hot grant that stays with the winner until that channel reports the end of its burst. One idle cycle follows each burst, and in it the next owner is chosen.

Two arbitration modes are selected by a mode input. With the mode input low, the arbiter runs a weighted round-robin: while both channels keep requesting, receive wins a number of bursts set by a 2-bit ratio field, then transmit wins one. With the mode input high, priority is fixed: receive wins every contested decision unless a swap input gives transmit the win. A lone requester is always served, whatever the mode and ratio.

Top module: `dma_bus_arb`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, rx_gnt_o and tx_gnt_o are both 0.
- R2: rx_gnt_o and tx_gnt_o are never 1 at the same time.
- R3: With the arbiter idle and exactly one channel requesting, that channel's grant rises at the next clock edge in either mode and for any ratio_i.
- R4: A grant that is 1 stays 1 at the next edge unless the owning channel's done input is 1 at that edge.
- R5: When the owning channel's done input is 1 at an edge, its grant is 0 after that edge, and a new grant can rise no earlier than the edge after.
- R6: With fixed_mode_i = 1 and tx_first_i = 0, a contested decision grants receive.
- R7: With fixed_mode_i = 1 and tx_first_i = 1, a contested decision grants transmit.
- R8: With fixed_mode_i = 0 and both channels requesting throughout, grants repeat as ratio_i+1 receive bursts followed by one transmit burst (ratio_i values 0, 1, 2, 3 give 1:1, 2:1, 3:1, 4:1).
- R9: Any cycle in which either request is 0 restarts the weighting, so the next contested run again begins with ratio_i+1 receive bursts.
- R10: tx_first_i has no effect when fixed_mode_i = 0.
- R11: A channel whose request is 0 in an idle cycle is not granted at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fixed_mode_i | input | 1 | 1 selects fixed priority, 0 weighted round-robin |
| tx_first_i | input | 1 | In fixed-priority mode, gives transmit the win |
| ratio_i | input | 2 | Receive bursts per transmit burst, minus one |
| rx_req_i | input | 1 | Receive channel request |
| tx_req_i | input | 1 | Transmit channel request |
| rx_done_i | input | 1 | Receive channel ends its burst |
| tx_done_i | input | 1 | Transmit channel ends its burst |
| rx_gnt_o | output | 1 | Bus granted to receive channel |
| tx_gnt_o | output | 1 | Bus granted to transmit channel |

## Verification
The bench records the exact owner sequence over several contested runs for every ratio value, so an off-by-one weighting counter shows up as a 1:1 run that grants transmit first or a 4:1 run that gives receive three or five bursts. It drops both requests for one cycle mid-run and expects a full receive share afterwards; a counter that never clears would hand the bus to transmit too early. It sets the swap bit in round-robin mode, where a design that leaked it into the weighted path would grant transmit first, and it holds grants across several cycles to catch an arbiter that re-decides before the burst ends.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2
  } owner_e;
endpackage

// File: rtl/dma_arb_ratio.sv
module dma_arb_ratio #(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               take_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               pick_tx_o
);
  localparam int CNT_W = RATIO_W + 1;

  logic [CNT_W-1:0] rx_wins_q;
  logic [CNT_W-1:0] rx_quota;

  // receive is allowed ratio+1 wins before transmit gets one
  assign rx_quota  = CNT_W'(ratio_i) + CNT_W'(1);
  assign pick_tx_o = (rx_wins_q >= rx_quota);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_wins_q <= '0;
    else if (clr_i)   rx_wins_q <= '0;
    else if (take_i)  rx_wins_q <= pick_tx_o ? '0 : rx_wins_q + CNT_W'(1);
  end

  p_cnt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !take_i) |=> !pick_tx_o);
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick (
  input  logic fixed_mode_i,
  input  logic tx_first_i,
  input  logic rr_pick_tx_i,
  input  logic rx_req_i,
  input  logic tx_req_i,
  output logic pick_rx_o,
  output logic pick_tx_o
);
  logic both;
  logic tx_wins;

  assign both    = rx_req_i & tx_req_i;
  assign tx_wins = fixed_mode_i ? tx_first_i : rr_pick_tx_i;

  always_comb begin
    pick_rx_o = 1'b0;
    pick_tx_o = 1'b0;
    if (both) begin
      pick_tx_o = tx_wins;
      pick_rx_o = !tx_wins;
    end else begin
      pick_rx_o = rx_req_i;
      pick_tx_o = tx_req_i;
    end
  end

  always_comb begin
    a_pick_onehot_r2: assert (!(pick_rx_o && pick_tx_o));
  end
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import dma_arb_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fixed_mode_i,
  input  logic               tx_first_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               rx_req_i,
  input  logic               tx_req_i,
  input  logic               rx_done_i,
  input  logic               tx_done_i,
  output logic               rx_gnt_o,
  output logic               tx_gnt_o
);
  owner_e owner_q, owner_d;
  logic   idle;
  logic   both_req;
  logic   rr_pick_tx;
  logic   pick_rx, pick_tx;
  logic   rr_take, rr_clr;

  assign idle     = (owner_q == OWN_NONE);
  assign both_req = rx_req_i & tx_req_i;
  assign rr_take  = idle & both_req & !fixed_mode_i;
  assign rr_clr   = !both_req | fixed_mode_i;

  dma_arb_ratio #(.RATIO_W(RATIO_W)) i_ratio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rr_clr),
    .take_i    (rr_take),
    .ratio_i   (ratio_i),
    .pick_tx_o (rr_pick_tx)
  );

  dma_arb_pick i_pick (
    .fixed_mode_i (fixed_mode_i),
    .tx_first_i   (tx_first_i),
    .rr_pick_tx_i (rr_pick_tx),
    .rx_req_i     (rx_req_i),
    .tx_req_i     (tx_req_i),
    .pick_rx_o    (pick_rx),
    .pick_tx_o    (pick_tx)
  );

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: if (pick_rx) owner_d = OWN_RX;
                else if (pick_tx) owner_d = OWN_TX;
      OWN_RX:   if (rx_done_i) owner_d = OWN_NONE;
      OWN_TX:   if (tx_done_i) owner_d = OWN_NONE;
      default:  owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  assign rx_gnt_o = (owner_q == OWN_RX);
  assign tx_gnt_o = (owner_q == OWN_TX);

  p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_gnt_o, tx_gnt_o}));
  p_rx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_gnt_o && !rx_done_i) |=> rx_gnt_o);
  p_tx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_gnt_o && !tx_done_i) |=> tx_gnt_o);
  p_rx_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_gnt_o && rx_done_i) |=> !rx_gnt_o && !tx_gnt_o);
  p_tx_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_gnt_o && tx_done_i) |=> !rx_gnt_o && !tx_gnt_o);
  p_fixed_rx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_gnt_o && !tx_gnt_o && both_req && fixed_mode_i && !tx_first_i) |=> rx_gnt_o);
  p_fixed_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_gnt_o && !tx_gnt_o && both_req && fixed_mode_i && tx_first_i) |=> tx_gnt_o);
  p_no_req_rx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_gnt_o && !tx_gnt_o && !rx_req_i) |=> !rx_gnt_o);
  p_no_req_tx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_gnt_o && !tx_gnt_o && !tx_req_i) |=> !tx_gnt_o);
endmodule

// File: tb/test_dma_bus_arb.sv
module test_dma_bus_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fixed_mode = 1'b0, tx_first = 1'b0;
  logic [1:0] ratio = 2'd0;
  logic       rx_req = 1'b0, tx_req = 1'b0, rx_done = 1'b0, tx_done = 1'b0;
  logic       rx_gnt, tx_gnt;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  dma_bus_arb i_dma_bus_arb (
    .clk_i(clk), .rst_ni(rst_n), .fixed_mode_i(fixed_mode), .tx_first_i(tx_first),
    .ratio_i(ratio), .rx_req_i(rx_req), .tx_req_i(tx_req), .rx_done_i(rx_done),
    .tx_done_i(tx_done), .rx_gnt_o(rx_gnt), .tx_gnt_o(tx_gnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 = none, 1 = rx, 2 = tx
  function automatic int who();
    return rx_gnt ? 1 : (tx_gnt ? 2 : 0);
  endfunction

  // wait for a grant, hold it, finish the burst; returns owner
  task automatic burst(output int owner);
    int w = 0;
    while (who() == 0 && w < 20) begin @(negedge clk); w++; end
    owner = who();
    repeat (2) begin
      @(negedge clk);
      chk(who() == owner, "R4", who(), owner);
    end
    chk(rx_gnt && tx_gnt ? 1'b0 : 1'b1, "R2", 1, 0);
    if (owner == 1) rx_done = 1'b1; else if (owner == 2) tx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0; tx_done = 1'b0;
    chk(who() == 0, "R5", who(), 0);
  endtask

  task automatic quiet();
    rx_req = 1'b0; tx_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(who() == 0, "R1", who(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(who() == 0, "R1", who(), 0);
  endtask

  task automatic t_single();
    int o;
    fixed_mode = 1'b0; ratio = 2'd3;
    tx_req = 1'b1;
    @(negedge clk);
    chk(who() == 2, "R3 tx alone rr", who(), 2);
    burst(o);
    burst(o);
    chk(o == 2, "R3 tx alone again", o, 2);
    quiet();
    fixed_mode = 1'b1; tx_first = 1'b0;
    tx_req = 1'b1;
    @(negedge clk);
    chk(who() == 2, "R3 tx alone fixed", who(), 2);
    burst(o);
    quiet();
    rx_req = 1'b1;
    @(negedge clk);
    chk(who() == 1, "R3 rx alone", who(), 1);
    chk(!tx_gnt, "R11 no tx without req", tx_gnt, 0);
    burst(o);
    quiet();
  endtask

  task automatic t_fixed();
    int o;
    fixed_mode = 1'b1; tx_first = 1'b0;
    rx_req = 1'b1; tx_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      burst(o);
      chk(o == 1, "R6 rx first", o, 1);
    end
    tx_first = 1'b1;
    for (int i = 0; i < 3; i++) begin
      burst(o);
      chk(o == 2, "R7 tx first", o, 2);
    end
    quiet();
  endtask

  task automatic t_weighted(input int r);
    int o;
    fixed_mode = 1'b0; tx_first = 1'b0; ratio = 2'(r);
    rx_req = 1'b1; tx_req = 1'b1;
    for (int round = 0; round < 2; round++) begin
      for (int k = 0; k <= r; k++) begin
        burst(o);
        chk(o == 1, $sformatf("R8 ratio %0d rx slot", r), o, 1);
      end
      burst(o);
      chk(o == 2, $sformatf("R8 ratio %0d tx slot", r), o, 2);
    end
    quiet();
  endtask

  task automatic t_restart();
    int o;
    fixed_mode = 1'b0; ratio = 2'd2;
    rx_req = 1'b1; tx_req = 1'b1;
    burst(o); burst(o);
    chk(o == 1, "R9 pre-drop rx", o, 1);
    rx_req = 1'b0; tx_req = 1'b0;
    @(negedge clk);
    chk(who() == 0, "R11 idle without req", who(), 0);
    rx_req = 1'b1; tx_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      burst(o);
      chk(o == 1, "R9 full share after drop", o, 1);
    end
    burst(o);
    chk(o == 2, "R9 tx after share", o, 2);
    quiet();
  endtask

  task automatic t_swap_ignored();
    int o;
    fixed_mode = 1'b0; tx_first = 1'b1; ratio = 2'd0;
    rx_req = 1'b1; tx_req = 1'b1;
    burst(o);
    chk(o == 1, "R10 swap ignored rr", o, 1);
    burst(o);
    chk(o == 2, "R10 rr alternates", o, 2);
    burst(o);
    chk(o == 1, "R10 rr alternates back", o, 1);
    quiet();
    tx_first = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_fixed();
    for (int r = 0; r < 4; r++) t_weighted(r);
    t_restart();
    t_swap_ignored();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule